// File: doc/BRIEF.md
# Intra 16x16 DC Predictor Value Generator

This block produces the single flat prediction level used by the DC mode of 16x16 luma intra prediction. A start pulse loads a packed neighbour array and a neighbour availability mask. The block then adds up the usable neighbour pixels over several cycles, a fixed number of lanes per cycle. It rounds and normalises the sum according to how many neighbour edges take part, and reports the 8-bit result with a one-cycle done pulse. The result stays on the output until the next accepted start.

The packed array carries 33 bytes. Left neighbours (top to bottom) sit at byte offsets 0 to 15, the corner pixel at offset 16, and the top neighbours (left to right) at offsets 17 to 32. Byte k occupies bits [8k+7:8k]. The corner byte never takes part in the result. Pixels of an edge marked unavailable are replaced by zero before they are summed. If the mask is entirely zero, the fixed mid-level 128 is reported instead.

Top module: `intra16_dc_pred`

## Requirements
- R1: While reset is high, and at the first clock edge after it, done_o is 0 and dc_o is 0.
- R2: Left pixels are read from byte offsets 0..15 and top pixels from offsets 17..32 of nbr_i. The byte at offset 16 never changes dc_o.
- R3: With avail_i bit 0 set and bit 2 clear, dc_o = (sum of the 16 left pixels + 8) >> 4.
- R4: With avail_i bit 2 set and bit 0 clear, dc_o = (sum of the 16 top pixels + 8) >> 4.
- R5: With avail_i bits 0 and 2 both set, dc_o = (sum of all 32 edge pixels + 16) >> 5.
- R6: With avail_i equal to 3'b000, dc_o = 128 whatever the pixel values are.
- R7: With avail_i nonzero but bits 0 and 2 both clear (only bit 1 set), no edge contributes, the rounding constant is 0 and the shift is 3, so dc_o = 0.
- R8: Pixels of an unavailable edge have no effect on dc_o, whatever their values.
- R9: done_o is a single-cycle pulse. It rises on the ninth clock edge after the edge that samples start_i high (LANES = 4), and it falls again on the next edge.
- R10: dc_o changes only on the edge where done_o rises, and holds its value until the next accepted operation completes.
- R11: A start_i pulse that arrives while an operation is in progress is ignored. It neither changes that operation's result nor produces an extra done pulse.
- R12: The result is limited to 8 bits. Neighbours that are all 255 give 255, and neighbours that are all 0 give 0, for every availability combination that includes an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| avail_i | input | 3 | Availability mask: bit 0 left edge, bit 2 top edge |
| nbr_i | input | 264 | Packed neighbour bytes (left 0..15, corner 16, top 17..32) |
| dc_o | output | 8 | DC prediction value, held between operations |
| done_o | output | 1 | One-cycle pulse when dc_o is updated |

## Verification
The hardest situation to reach from the ports is a second start that arrives mid-accumulation with different neighbours and a different mask. If such a start were wrongly accepted, the result would mix the two pixel sets. The bench raises start again a few cycles into a running operation, with contrasting data. It then checks that the first operation's value is reported, that no second done pulse appears, and that dc_o stays steady afterwards. Random mask and pixel mixes are combined with directed all-0, all-255, corner-byte and bit-1-only cases, so that each rounding and shift branch is exercised.

// File: rtl/intra16_dc_pkg.sv
package intra16_dc_pkg;

    localparam int PIX_W      = 8;
    localparam int EDGE_LEN   = 16;
    localparam int NBR_BYTES  = 2 * EDGE_LEN + 1;
    localparam int TOP_BASE   = EDGE_LEN + 1;
    localparam int TOTAL_PIX  = 2 * EDGE_LEN;
    localparam int PIX_MAX    = (1 << PIX_W) - 1;
    localparam int SUM_W      = $clog2(TOTAL_PIX * PIX_MAX + 1);
    localparam int AVAIL_W    = 3;
    localparam int LEFT_BIT   = 0;
    localparam int TOP_BIT    = 2;
    localparam int BASE_SHIFT = 3;
    localparam int RND_STEP   = 8;
    localparam logic [PIX_W-1:0] DC_NONE = PIX_W'(1 << (PIX_W - 1));

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_FIN  = 2'd2
    } dc_state_e;

    typedef struct packed {
        logic left;
        logic top;
        logic none;
    } edge_av_t;

    function automatic edge_av_t decode_avail(input logic [AVAIL_W-1:0] m);
        edge_av_t r;
        r.left = m[LEFT_BIT];
        r.top  = m[TOP_BIT];
        r.none = (m == '0);
        return r;
    endfunction

    function automatic logic [PIX_W-1:0] dc_normalize(input logic [SUM_W-1:0] sum,
                                                      input edge_av_t av);
        int unsigned n_edges;
        logic [SUM_W+1:0] acc;
        n_edges = int'(av.left) + int'(av.top);
        acc = {2'b00, sum} + (SUM_W+2)'(RND_STEP * n_edges);
        acc = acc >> (BASE_SHIFT + n_edges);
        if (av.none)
            return DC_NONE;
        if (acc > (SUM_W+2)'(PIX_MAX))
            return PIX_W'(PIX_MAX);
        return acc[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/dcp_edge_gather.sv
module dcp_edge_gather
    import intra16_dc_pkg::*;
(
    input  logic [NBR_BYTES*PIX_W-1:0] nbr,
    input  edge_av_t                   av,
    output logic [TOTAL_PIX*PIX_W-1:0] pix
);

    for (genvar p = 0; p < TOTAL_PIX; p++) begin : g_pix
        if (p < EDGE_LEN) begin : g_left
            assign pix[p*PIX_W +: PIX_W] =
                av.left ? nbr[p*PIX_W +: PIX_W] : '0;
        end else begin : g_top
            assign pix[p*PIX_W +: PIX_W] =
                av.top ? nbr[(TOP_BASE + p - EDGE_LEN)*PIX_W +: PIX_W] : '0;
        end
    end

endmodule

// File: rtl/dcp_lane_accum.sv
module dcp_lane_accum
    import intra16_dc_pkg::*;
#(
    parameter int LANES = 4,
    localparam int STEPS = TOTAL_PIX / LANES,
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       en,
    input  logic [IDX_W-1:0]           idx,
    input  logic [TOTAL_PIX*PIX_W-1:0] pix,
    output logic [SUM_W-1:0]           sum
);

    logic [SUM_W-1:0] part;
    logic [SUM_W-1:0] sum_q;

    always_comb begin
        part = '0;
        for (int l = 0; l < LANES; l++) begin
            part = part + SUM_W'(pix[(int'(idx) * LANES + l) * PIX_W +: PIX_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum_q <= '0;
        else if (en)
            sum_q <= sum_q + part;
    end

    assign sum = sum_q;

endmodule

// File: rtl/dcp_round_norm.sv
module dcp_round_norm
    import intra16_dc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SUM_W-1:0] sum,
    input  edge_av_t         av,
    output logic [PIX_W-1:0] dc,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dc   <= '0;
            done <= 1'b0;
        end else begin
            done <= load;
            if (load)
                dc <= dc_normalize(sum, av);
        end
    end

endmodule

// File: rtl/intra16_dc_pred.sv
module intra16_dc_pred
    import intra16_dc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start_i,
    input  logic [AVAIL_W-1:0]         avail_i,
    input  logic [NBR_BYTES*PIX_W-1:0] nbr_i,
    output logic [PIX_W-1:0]           dc_o,
    output logic                       done_o
);

    localparam int STEPS = TOTAL_PIX / LANES;
    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    dc_state_e                  state;
    logic [IDX_W-1:0]           idx_q;
    logic [NBR_BYTES*PIX_W-1:0] nbr_q;
    logic [AVAIL_W-1:0]         mask_q;
    logic [TOTAL_PIX*PIX_W-1:0] pix;
    logic [SUM_W-1:0]           sum;
    edge_av_t                   av;
    logic                       busy;
    logic                       accept;

    assign busy   = (state != ST_IDLE);
    assign accept = start_i && !busy;
    assign av     = decode_avail(mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            nbr_q  <= '0;
            mask_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        nbr_q  <= nbr_i;
                        mask_q <= avail_i;
                        idx_q  <= '0;
                        state  <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_W'(STEPS - 1))
                        state <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    dcp_edge_gather u_gather (
        .nbr (nbr_q),
        .av  (av),
        .pix (pix)
    );

    dcp_lane_accum #(.LANES(LANES)) u_accum (
        .clk (clk),
        .rst (rst),
        .clr (accept),
        .en  (state == ST_ACC),
        .idx (idx_q),
        .pix (pix),
        .sum (sum)
    );

    dcp_round_norm u_norm (
        .clk  (clk),
        .rst  (rst),
        .load (state == ST_FIN),
        .sum  (sum),
        .av   (av),
        .dc   (dc_o),
        .done (done_o)
    );

endmodule

// File: rtl/intra16_dc_pred_chk.sv
module intra16_dc_pred_chk
    import intra16_dc_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               done_o,
    input logic [PIX_W-1:0]   dc_o,
    input logic               busy,
    input logic [AVAIL_W-1:0] mask_q
);

    localparam int LAT = TOTAL_PIX / LANES + 2;

    logic [15:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            lat_cnt <= '0;
        else if (start_i && !busy)
            lat_cnt <= 16'd1;
        else if (done_o)
            lat_cnt <= '0;
        else if (lat_cnt != '0)
            lat_cnt <= lat_cnt + 16'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!done_o && dc_o == '0));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (lat_cnt == 16'(LAT)));

    // R10
    dc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(dc_o));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy && lat_cnt != '0) |=> (lat_cnt == $past(lat_cnt) + 16'd1 || done_o));

    // R6
    no_edge_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && mask_q == '0) |-> (dc_o == DC_NONE));

    // R7
    odd_mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && mask_q != '0 && !mask_q[LEFT_BIT] && !mask_q[TOP_BIT]) |-> (dc_o == '0));

endmodule

bind intra16_dc_pred intra16_dc_pred_chk #(.LANES(LANES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_o  (done_o),
    .dc_o    (dc_o),
    .busy    (busy),
    .mask_q  (mask_q)
);

// File: tb/intra16_dc_pred_test.sv
module intra16_dc_pred_test;
    import intra16_dc_pkg::*;

    localparam int LANES = 4;
    localparam int STEPS = TOTAL_PIX / LANES;
    localparam int NW    = NBR_BYTES * PIX_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    mask = '0;
    logic [NW-1:0] nbr = '0;
    logic [7:0]    dc;
    logic          done;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int unsigned seed_dummy;

    always #2 clk = ~clk;

    intra16_dc_pred #(.LANES(LANES)) uut (
        .clk(clk), .rst(rst), .start_i(start), .avail_i(mask),
        .nbr_i(nbr), .dc_o(dc), .done_o(done)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic int exp_dc(input logic [NW-1:0] n, input logic [2:0] m);
        int s = 0;
        int k = 0;
        if (m == 3'b000) return 128;
        if (m[0]) begin
            for (int i = 0; i < 16; i++) s += n[i*8 +: 8];
            k++;
        end
        if (m[2]) begin
            for (int i = 0; i < 16; i++) s += n[(17+i)*8 +: 8];
            k++;
        end
        s = (s + 8*k) >> (3 + k);
        return (s > 255) ? 255 : s;
    endfunction

    function automatic logic [NW-1:0] fill(input logic [7:0] lv, input logic [7:0] cv,
                                           input logic [7:0] tv);
        logic [NW-1:0] r;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = lv;
        r[16*8 +: 8] = cv;
        for (int i = 0; i < 16; i++) r[(17+i)*8 +: 8] = tv;
        return r;
    endfunction

    function automatic logic [NW-1:0] rnd_nbr();
        logic [NW-1:0] r;
        for (int i = 0; i < NBR_BYTES; i++) r[i*8 +: 8] = 8'($urandom);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic run_op(input logic [NW-1:0] n, input logic [2:0] m,
                          input string req, output int got_dc);
        int k = 0;
        bit seen = 0;
        @(negedge clk);
        nbr = n; mask = m; start = 1'b1;
        while (!seen && k < 40) begin
            @(negedge clk);
            start = 1'b0;
            k++;
            if (done) seen = 1;
        end
        check(seen && k == STEPS + 2, "R9 latency", k, STEPS + 2);
        got_dc = dc;
        check(dc == 8'(exp_dc(n, m)), req, dc, exp_dc(n, m));
        @(negedge clk);
        check(!done, "R9 pulse width", done, 0);
    endtask

    initial begin
        int r0;
        int r1;
        logic [NW-1:0] a;
        logic [NW-1:0] b;
        seed_dummy = $urandom(32'h1D6C);

        repeat (3) @(negedge clk);
        check(!done && dc == 0, "R1 in reset", dc, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && dc == 0, "R1 after reset", dc, 0);

        // R12 extremes for every edge combination
        run_op(fill(8'hFF, 8'hFF, 8'hFF), 3'b101, "R12 R5 all 255", r0);
        run_op(fill(8'hFF, 8'hFF, 8'hFF), 3'b001, "R12 R3 all 255", r0);
        run_op(fill(8'hFF, 8'hFF, 8'hFF), 3'b100, "R12 R4 all 255", r0);
        run_op(fill(8'h00, 8'h00, 8'h00), 3'b101, "R12 all 0", r0);
        run_op(fill(8'h00, 8'h00, 8'h00), 3'b001, "R12 left 0", r0);

        // R6 no edge available
        run_op(fill(8'hFF, 8'h00, 8'h00), 3'b000, "R6 mid level", r0);
        check(r0 == 128, "R6 value", r0, 128);
        // R7 only bit 1
        run_op(fill(8'hFF, 8'hFF, 8'hFF), 3'b010, "R7 bit1 only", r0);
        check(r0 == 0, "R7 value", r0, 0);

        // R8 unavailable edge ignored
        run_op(fill(8'hFF, 8'h00, 8'h10), 3'b100, "R8 left ignored", r0);
        check(r0 == 16, "R8 top 16", r0, 16);
        run_op(fill(8'h20, 8'h00, 8'hFF), 3'b001, "R8 top ignored", r0);
        check(r0 == 32, "R8 left 32", r0, 32);

        // R2 corner byte unused, offsets placement
        a = rnd_nbr();
        b = a;
        a[16*8 +: 8] = 8'h00;
        b[16*8 +: 8] = 8'hFF;
        run_op(a, 3'b101, "R2 corner 0", r0);
        run_op(b, 3'b101, "R2 corner FF", r1);
        check(r0 == r1, "R2 corner invariant", r1, r0);
        a = fill(8'h00, 8'hFF, 8'h00);
        a[15*8 +: 8] = 8'd160;
        a[17*8 +: 8] = 8'd64;
        run_op(a, 3'b101, "R2 R5 edge bytes", r0);
        check(r0 == 7, "R2 edge bytes", r0, 7);

        // R11 start while busy ignored, R10 hold
        a = fill(8'd10, 8'd0, 8'd30);
        b = fill(8'd200, 8'd0, 8'd250);
        begin
            int k = 0;
            int dcount = 0;
            @(negedge clk);
            nbr = a; mask = 3'b101; start = 1'b1;
            @(negedge clk); start = 1'b0; k = 1;
            repeat (3) begin @(negedge clk); k++; end
            nbr = b; mask = 3'b001; start = 1'b1;
            @(negedge clk); start = 1'b0; k++;
            nbr = b;
            while (k < STEPS + 2) begin
                @(negedge clk); k++;
                if (done) dcount++;
            end
            check(done && dc == 20, "R11 first result kept", dc, 20);
            repeat (STEPS + 4) begin
                @(negedge clk);
                if (done) dcount++;
            end
            check(dcount == 1, "R11 single done", dcount, 1);
            check(dc == 20, "R10 dc held", dc, 20);
        end

        // random mixes
        for (int t = 0; t < 40; t++) begin
            logic [2:0] m;
            m = 3'($urandom);
            a = rnd_nbr();
            case (m)
                3'b001, 3'b011: run_op(a, m, "R3 random left", r0);
                3'b100, 3'b110: run_op(a, m, "R4 random top", r0);
                3'b101, 3'b111: run_op(a, m, "R5 random both", r0);
                3'b000:         run_op(a, m, "R6 random none", r0);
                default:        run_op(a, m, "R7 random odd", r0);
            endcase
            repeat (2) @(negedge clk);
            check(dc == 8'(r0), "R10 random hold", dc, r0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule